// File: doc/BRIEF.md
# Configurable-format serial receiver

This block recovers asynchronous serial characters from a single line. A three-bit format code selects the character layout at the start of each character: seven or eight data bits, no parity or even or odd parity, and one or two stop bits. An external rate unit supplies a one-cycle enable tick at sixteen times the bit rate. The receiver does all of its timing with these ticks. It confirms a start bit at its midpoint and then samples every later bit at its centre.

A finished character is placed on an 8-bit output, and a ready flag is raised. Parity, framing and overrun problems each have their own sticky flag. A one-cycle read strobe from the host consumes the character and clears the ready flag and all three error flags. A synchronous active-high reset returns the block to idle with every flag low. The surrounding logic drives that reset both for a hardware reset and for a software reset.

Top module: `serial_frame_rx`

## Requirements
- R1: Format code decode. Bit 2 set selects 8 data bits and clear selects 7. Codes 000 and 001 carry parity with 2 stop bits. Codes 010, 011, 110 and 111 carry parity with 1 stop bit. Code 100 has no parity and 2 stop bits. Code 101 has no parity and 1 stop bit. Where parity is present, an even code value selects even parity and an odd code value selects odd parity.
- R2: Data bits are received least significant bit first and appear on `data_out[6:0]` or `data_out[7:0]`. In 7-bit formats `data_out[7]` reads 0.
- R3: A start is accepted only on a falling level after the line has been seen high on a tick, and only if the line is still low 8 ticks later. Shorter low pulses are dropped, and no character results.
- R4: `data_ready` rises only when a character completes. `data_out` and the flags hold their values while no character completes and no read occurs.
- R5: `err_parity` is set for a character whose parity bit does not match the selected sense. Even means the data bits plus the parity bit hold an even number of ones. The flag is never set in a no-parity format.
- R6: `err_frame` is set when any stop-bit sample of a character is low. In 2-stop formats this includes a low second stop bit. The data is still delivered.
- R7: `err_overrun` is set when a character completes while `data_ready` is still set and no read occurs in that cycle. The newer character replaces the older one.
- R8: A `rd_strobe` cycle with no character completing clears `data_ready`, `err_frame`, `err_parity` and `err_overrun` on the next clock edge.
- R9: While `rst` is high, every flag clears on the next edge, and the receiver returns to idle.
- R10: Bit timing advances only on `tick` cycles. With no ticks, line activity produces no character. A tick spacing of any number of clock cycles gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Serial line, idles high |
| fmt_code | input | 3 | Character format selector |
| rd_strobe | input | 1 | Host read, consumes the character |
| data_out | output | 8 | Last received character |
| data_ready | output | 1 | Character waiting |
| err_frame | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Character arrived before the previous was read |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and a 2-stage line synchronizer. With 16 ticks per bit, a start pulse of four ticks falls well short of the 8-tick midpoint check. That makes the glitch-rejection path reachable. The tick is driven on every cycle and also on every third cycle. This shows that character timing follows the tick count and not the clock.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // Map the 3-bit format selector onto its character layout.
  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f.eight    = code[2];
    f.par_en   = !(code[2] && !code[1]);
    f.par_odd  = code[0];
    f.two_stop = code[2] ? (code == 3'b100) : !code[1];
    return f;
  endfunction

  // High when the received parity bit disagrees with the chosen sense.
  function automatic logic parity_bad(input logic [7:0] d, input logic eight,
                                      input logic pbit, input logic odd);
    logic ones;
    ones = eight ? ^d : ^d[6:0];
    return ones ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic [2:0] fmt_code,
  output logic       bit_strobe,
  output logic       start_ok,
  output logic       frame_done,
  output logic [7:0] frame_data,
  output logic       frame_perr,
  output logic       frame_ferr,
  output logic       frame_eight
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS / 2 - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic          sidx;
  logic          armed;
  logic          pbit_q;
  logic          ferr_acc;
  logic [7:0]    shreg;
  fmt_t          fmt_q;
  logic [2:0]    last_bit;

  assign last_bit   = fmt_q.eight ? 3'd7 : 3'd6;
  assign bit_strobe = tick && cnt == LAST_CNT &&
                      (st == ST_DATA || st == ST_PAR || st == ST_STOP);
  assign start_ok   = tick && st == ST_START && cnt == MID_CNT && !line;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      sidx       <= 1'b0;
      armed      <= 1'b0;
      pbit_q     <= 1'b0;
      ferr_acc   <= 1'b0;
      shreg      <= '0;
      fmt_q      <= '0;
      frame_done <= 1'b0;
      frame_ferr <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (line) armed <= 1'b1;
            else if (armed) begin
              st    <= ST_START;
              cnt   <= '0;
              armed <= 1'b0;
              fmt_q <= decode_fmt(fmt_code);
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (!line) begin
                st       <= ST_DATA;
                bidx     <= '0;
                shreg    <= '0;
                ferr_acc <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt         <= '0;
              shreg[bidx] <= line;
              if (bidx == last_bit) begin
                st   <= fmt_q.par_en ? ST_PAR : ST_STOP;
                sidx <= 1'b0;
              end else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == LAST_CNT) begin
              cnt    <= '0;
              pbit_q <= line;
              st     <= ST_STOP;
              sidx   <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == LAST_CNT) begin
              cnt <= '0;
              if (fmt_q.two_stop && !sidx) begin
                sidx     <= 1'b1;
                ferr_acc <= ferr_acc | !line;
              end else begin
                st         <= ST_IDLE;
                frame_done <= 1'b1;
                frame_ferr <= ferr_acc | !line;
              end
            end else cnt <= cnt + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign frame_data  = shreg;
  assign frame_eight = fmt_q.eight;
  assign frame_perr  = fmt_q.par_en &&
                       parity_bad(shreg, fmt_q.eight, pbit_q, fmt_q.par_odd);
endmodule

// File: rtl/sfr_status.sv
module sfr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_done,
  input  logic [7:0] frame_data,
  input  logic       frame_perr,
  input  logic       frame_ferr,
  input  logic       rd_strobe,
  output logic [7:0] data_out,
  output logic       data_ready,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_out    <= '0;
      data_ready  <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else if (frame_done) begin
      data_out    <= frame_data;
      data_ready  <= 1'b1;
      err_frame   <= frame_ferr;
      err_parity  <= frame_perr;
      err_overrun <= data_ready && !rd_strobe;
    end else if (rd_strobe) begin
      data_ready  <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_line,
  input  logic [2:0] fmt_code,
  input  logic       rd_strobe,
  output logic [7:0] data_out,
  output logic       data_ready,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);
  logic       line_s;
  logic       bit_strobe;
  logic       start_ok;
  logic       frame_done;
  logic [7:0] frame_data;
  logic       frame_perr;
  logic       frame_ferr;
  logic       frame_eight;

  sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
  );

  sfr_frame_ctrl #(.OVS(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .line(line_s), .fmt_code(fmt_code),
    .bit_strobe(bit_strobe), .start_ok(start_ok), .frame_done(frame_done),
    .frame_data(frame_data), .frame_perr(frame_perr),
    .frame_ferr(frame_ferr), .frame_eight(frame_eight)
  );

  sfr_status u_stat (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_data(frame_data),
    .frame_perr(frame_perr), .frame_ferr(frame_ferr), .rd_strobe(rd_strobe),
    .data_out(data_out), .data_ready(data_ready), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       rd_strobe,
  input logic       frame_done,
  input logic       bit_strobe,
  input logic       frame_eight,
  input logic [7:0] data_out,
  input logic       data_ready,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_overrun
);
  assert_ready_from_frame_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(frame_done));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!frame_done && !rd_strobe) |=> ($stable(data_out) && $stable(data_ready)
                                     && $stable(err_frame) && $stable(err_parity)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=> (!data_ready && !err_frame && !err_parity && !err_overrun));

  assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && data_ready && !rd_strobe) |=> err_overrun);

  assert_seven_bit_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_eight) |=> !data_out[7]);

  assert_done_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(bit_strobe && tick));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!data_ready && !err_frame && !err_parity && !err_overrun));
endmodule

bind serial_frame_rx sfr_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rd_strobe(rd_strobe),
  .frame_done(frame_done), .bit_strobe(bit_strobe), .frame_eight(frame_eight),
  .data_out(data_out), .data_ready(data_ready), .err_frame(err_frame),
  .err_parity(err_parity), .err_overrun(err_overrun)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [2:0] fmt_code = 3'b000;
  logic       rd_strobe = 1'b0;
  logic [7:0] data_out;
  logic       data_ready, err_frame, err_parity, err_overrun;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_div = 1;
  int tcnt     = 0;
  logic tick_en = 1'b1;

  always #4 clk = ~clk;

  serial_frame_rx dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line), .fmt_code(fmt_code),
    .rd_strobe(rd_strobe), .data_out(data_out), .data_ready(data_ready),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );

  always @(negedge clk) begin
    tick = tick_en && (tcnt == 0);
    tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_ticks(input int n);
    repeat (n * tick_div) @(negedge clk);
  endtask

  // Bench-side layout table, written independently of the design.
  task automatic layout(input logic [2:0] c, output int nbits, output int par,
                        output int odd, output int nstop);
    case (c)
      3'b000: begin nbits = 7; par = 1; odd = 0; nstop = 2; end
      3'b001: begin nbits = 7; par = 1; odd = 1; nstop = 2; end
      3'b010: begin nbits = 7; par = 1; odd = 0; nstop = 1; end
      3'b011: begin nbits = 7; par = 1; odd = 1; nstop = 1; end
      3'b100: begin nbits = 8; par = 0; odd = 0; nstop = 2; end
      3'b101: begin nbits = 8; par = 0; odd = 0; nstop = 1; end
      3'b110: begin nbits = 8; par = 1; odd = 0; nstop = 1; end
      default: begin nbits = 8; par = 1; odd = 1; nstop = 1; end
    endcase
  endtask

  task automatic send_frame(input logic [2:0] c, input logic [7:0] d,
                            input logic flip, input logic [1:0] stop_low);
    int nbits, par, odd, nstop, ones;
    layout(c, nbits, par, odd, nstop);
    fmt_code = c;
    ones = 0;
    rx_line = 1'b0; hold_ticks(16);
    for (int i = 0; i < nbits; i++) begin
      rx_line = d[i]; ones += d[i]; hold_ticks(16);
    end
    if (par != 0) begin
      rx_line = logic'((ones % 2) ^ odd) ^ flip; hold_ticks(16);
    end
    for (int s = 0; s < nstop; s++) begin
      rx_line = !stop_low[s]; hold_ticks(16);
    end
    rx_line = 1'b1; hold_ticks(24);
  endtask

  task automatic do_read;
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 ready after reset", data_ready, 0);
    check("R9 frame err after reset", err_frame, 0);
    check("R9 parity err after reset", err_parity, 0);
    check("R9 overrun after reset", err_overrun, 0);
  endtask

  task automatic t_formats;
    logic [7:0] pat [8] = '{8'hA5, 8'h3C, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'hC3, 8'h96};
    for (int c = 0; c < 8; c++) begin
      logic [7:0] exp_d;
      exp_d = (c < 4) ? (pat[c] & 8'h7F) : pat[c];
      send_frame(3'(c), pat[c], 1'b0, 2'b00);
      check($sformatf("R1 R2 ready fmt %0d", c), data_ready, 1);
      check($sformatf("R1 R2 data fmt %0d", c), data_out, exp_d);
      check($sformatf("R5 no parity err fmt %0d", c), err_parity, 0);
      check($sformatf("R6 no frame err fmt %0d", c), err_frame, 0);
      do_read();
      check($sformatf("R8 ready cleared fmt %0d", c), data_ready, 0);
    end
  endtask

  task automatic t_parity;
    send_frame(3'b011, 8'h4B, 1'b1, 2'b00);
    check("R5 odd parity mismatch flagged", err_parity, 1);
    check("R5 data kept", data_out, 8'h4B);
    do_read();
    send_frame(3'b110, 8'h0F, 1'b1, 2'b00);
    check("R5 even parity mismatch flagged", err_parity, 1);
    do_read();
    check("R8 parity err cleared", err_parity, 0);
    send_frame(3'b101, 8'h77, 1'b1, 2'b00);
    check("R5 no-parity format never flags", err_parity, 0);
    do_read();
  endtask

  task automatic t_framing;
    send_frame(3'b000, 8'h55, 1'b0, 2'b10);
    check("R6 second stop low flagged", err_frame, 1);
    check("R6 data still delivered", data_out, 8'h55);
    do_read();
    check("R8 frame err cleared", err_frame, 0);
    send_frame(3'b101, 8'hE7, 1'b0, 2'b01);
    check("R6 single stop low flagged", err_frame, 1);
    do_read();
    send_frame(3'b101, 8'h12, 1'b0, 2'b00);
    check("R3 clean frame after low stop", data_out, 8'h12);
    check("R6 flag gone on clean frame", err_frame, 0);
    do_read();
  endtask

  task automatic t_overrun;
    send_frame(3'b111, 8'h11, 1'b0, 2'b00);
    check("R7 no overrun on first", err_overrun, 0);
    send_frame(3'b111, 8'h22, 1'b0, 2'b00);
    check("R7 overrun set", err_overrun, 1);
    check("R7 newer byte kept", data_out, 8'h22);
    do_read();
    check("R8 overrun cleared", err_overrun, 0);
  endtask

  task automatic t_glitch;
    rx_line = 1'b0; hold_ticks(4);
    rx_line = 1'b1; hold_ticks(200);
    check("R3 short low pulse ignored", data_ready, 0);
  endtask

  task automatic t_no_tick;
    tick_en = 1'b0;
    rx_line = 1'b0; repeat (300) @(negedge clk);
    rx_line = 1'b1; repeat (50) @(negedge clk);
    tick_en = 1'b1;
    hold_ticks(250);
    check("R10 no character without ticks", data_ready, 0);
  endtask

  task automatic t_slow_tick;
    tick_div = 3;
    hold_ticks(4);
    send_frame(3'b110, 8'hB4, 1'b0, 2'b00);
    check("R10 slow tick ready", data_ready, 1);
    check("R10 slow tick data", data_out, 8'hB4);
    check("R10 slow tick parity ok", err_parity, 0);
    do_read();
    tick_div = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    hold_ticks(4);
    t_formats();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    t_no_tick();
    t_slow_tick();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule